// File: doc/BRIEF.md
# Serial Channel Status Flags and Interrupt Requests

This block keeps the status flags of one asynchronous serial channel and turns them into interrupt requests. It holds six flags: transmit holding register empty, receive buffer full, transmit complete, and three receive errors (overrun, framing, parity). Single-cycle event pulses from the shift engines set the flags. The CPU clears a flag by reading the status word and then writing 0 to that bit. A DMA access to a data register clears the matching flag in hardware.

Four request lines leave the block, one for each source: receive error, receive full, transmit empty and transmit complete. Three enable inputs gate them. A 2-bit code names the highest-priority pending request. The receive-full and transmit-empty requests can also start a DMA transfer, so the block emits a one-cycle trigger strobe when either of them turns on. The block also holds the transmit holding register, which accepts every write.

Top module: `uart_flag_irq`

## Requirements
- R1: After reset, the status word `sts_rdata` is 6'b100001. Its bits are: bit0 transmit empty, bit1 receive full, bit2 overrun, bit3 framing error, bit4 parity error, bit5 transmit complete. After reset all requests, both strobes and `irq_valid` are 0, and `tdr_data` is 0.
- R2: An `ev_tx_load` pulse sets transmit empty in the next cycle. `irq_txempty` equals transmit empty AND `en_tx`.
- R3: An `ev_rx_done` pulse sets receive full. `irq_rxfull` equals receive full AND `en_rx`.
- R4: An `ev_overrun`, `ev_frame_err` or `ev_parity_err` pulse sets its error bit. `irq_rxerr` is 1 when any error bit is 1 and `en_rx` is 1.
- R5: An `ev_stop_done` pulse sets transmit complete only while transmit empty is 1. Any write to the transmit holding register (CPU or DMA) clears transmit complete. `irq_txend` equals transmit complete AND `en_txend`.
- R6: `dma_tdr_wr` clears transmit empty, and `dma_rdr_rd` clears receive full. A CPU write to the transmit holding register leaves transmit empty unchanged.
- R7: `dma_tx_trig` and `dma_rx_trig` pulse for exactly one cycle when `irq_txempty` or `irq_rxfull`, respectively, goes from 0 to 1. The error and transmit-complete requests never produce a strobe.
- R8: `irq_src` names the highest pending enabled request: 0 receive error, 1 receive full, 2 transmit empty, 3 transmit complete, with 0 the highest priority. `irq_valid` is 1 when any request is 1. `irq_src` is 0 when no request is pending.
- R9: A CPU clear takes two steps: an `sts_rd` pulse, then an `sts_wr` pulse. The write clears each bit that read as 1 and is written as 0. Writing 1 has no effect. A write without a preceding read has no effect. Each read allows only one write.
- R10: A set event in the same cycle as any clear of the same flag leaves the flag at 1.
- R11: Every write to the transmit holding register is accepted, whatever the transmit empty flag shows. A later write overwrites a byte that was never loaded into the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_tx_load | input | 1 | Holding register moved into the transmit shifter |
| ev_stop_done | input | 1 | Last stop bit sent |
| ev_rx_done | input | 1 | Received byte placed in the receive buffer |
| ev_overrun | input | 1 | Receive overrun detected |
| ev_frame_err | input | 1 | Framing error detected |
| ev_parity_err | input | 1 | Parity error detected |
| cpu_tdr_wr | input | 1 | CPU write to the transmit holding register |
| dma_tdr_wr | input | 1 | DMA write to the transmit holding register |
| tdr_wdata | input | DATA_W | Write data for the holding register |
| dma_rdr_rd | input | 1 | DMA read of the receive buffer |
| sts_rd | input | 1 | CPU read of the status word |
| sts_wr | input | 1 | CPU write of the status word |
| sts_wdata | input | 6 | Status write data |
| en_tx | input | 1 | Transmit-empty request enable |
| en_rx | input | 1 | Receive-full and receive-error request enable |
| en_txend | input | 1 | Transmit-complete request enable |
| sts_rdata | output | 6 | Current flag word |
| tdr_data | output | DATA_W | Transmit holding register contents |
| irq_rxerr | output | 1 | Receive error request |
| irq_rxfull | output | 1 | Receive full request |
| irq_txempty | output | 1 | Transmit empty request |
| irq_txend | output | 1 | Transmit complete request |
| dma_rx_trig | output | 1 | DMA strobe for receive |
| dma_tx_trig | output | 1 | DMA strobe for transmit |
| irq_src | output | 2 | Highest pending request code |
| irq_valid | output | 1 | Any request pending |

## Verification
Every flag is visible on `sts_rdata` one cycle after the edge that changes it. A corrupted flag therefore shows at once as a wrong status bit, and as a wrong request line or `irq_src` in the same cycle. A stale arm bit in the clear protocol only shows up when a later write clears a flag that should have survived. The bench therefore writes without reading first, and writes twice after a single read. A broken edge register on the DMA strobes shows as a strobe that is missing, or one that lasts longer than one cycle, in the cycle after the flag is set.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int FLAG_N = 6;
  localparam int F_TXE  = 0;
  localparam int F_RXF  = 1;
  localparam int F_OVR  = 2;
  localparam int F_FRM  = 3;
  localparam int F_PAR  = 4;
  localparam int F_TEND = 5;
  localparam logic [FLAG_N-1:0] FLAG_RST = 6'b100001;

  localparam int REQ_N = 4;
  typedef enum logic [1:0] {
    SRC_RXERR   = 2'd0,
    SRC_RXFULL  = 2'd1,
    SRC_TXEMPTY = 2'd2,
    SRC_TXEND   = 2'd3
  } src_t;

  // req bit order: 0 rx error, 1 rx full, 2 tx empty, 3 tx end; lower index wins
  function automatic src_t pick_src(input logic [REQ_N-1:0] req);
    if (req[0])      return SRC_RXERR;
    else if (req[1]) return SRC_RXFULL;
    else if (req[2]) return SRC_TXEMPTY;
    else if (req[3]) return SRC_TXEND;
    else             return SRC_RXERR;
  endfunction
endpackage

// File: rtl/flag_cell.sv
module flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic sw_clr_i,
  output logic q
);
  logic clr_any;
  assign clr_any = hw_clr_i | sw_clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= RST_VAL;
    else if (set_i)   q <= 1'b1;
    else if (clr_any) q <= 1'b0;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
  assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_any && !set_i) |=> !q);
endmodule

// File: rtl/flag_clr_ctl.sv
module flag_clr_ctl #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] flags_i,
  output logic [N-1:0] sw_clr_o
);
  logic [N-1:0] arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    arm_q <= '0;
    else if (wr_i) arm_q <= '0;
    else if (rd_i) arm_q <= flags_i;
  end

  assign sw_clr_o = {N{wr_i}} & arm_q & ~wdata_i;

  assert_arm_spent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (arm_q == '0));
endmodule

// File: rtl/tdr_hold.sv
module tdr_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (wr_i) q <= wdata_i;
  end

  assert_write_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (q == $past(wdata_i)));
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import uart_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] flags_i,
  input  logic              en_tx,
  input  logic              en_rx,
  input  logic              en_txend,
  output logic [REQ_N-1:0]  req_o,
  output logic              dma_rx_trig,
  output logic              dma_tx_trig,
  output logic [1:0]        src_o,
  output logic              valid_o
);
  logic rx_q, tx_q;
  logic any_err;

  assign any_err  = flags_i[F_OVR] | flags_i[F_FRM] | flags_i[F_PAR];
  assign req_o[0] = any_err & en_rx;
  assign req_o[1] = flags_i[F_RXF] & en_rx;
  assign req_o[2] = flags_i[F_TXE] & en_tx;
  assign req_o[3] = flags_i[F_TEND] & en_txend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      rx_q <= req_o[1];
      tx_q <= req_o[2];
    end
  end

  assign dma_rx_trig = req_o[1] & ~rx_q;
  assign dma_tx_trig = req_o[2] & ~tx_q;
  assign src_o       = pick_src(req_o);
  assign valid_o     = |req_o;

  assert_dma_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rx_trig || dma_tx_trig) |=> !($past(dma_rx_trig) && dma_rx_trig) && !($past(dma_tx_trig) && dma_tx_trig));
  assert_src_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> req_o[src_o]);
  assert_rxerr_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_o[0] |-> en_rx);
endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq
  import uart_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tx_load,
  input  logic              ev_stop_done,
  input  logic              ev_rx_done,
  input  logic              ev_overrun,
  input  logic              ev_frame_err,
  input  logic              ev_parity_err,
  input  logic              cpu_tdr_wr,
  input  logic              dma_tdr_wr,
  input  logic [DATA_W-1:0] tdr_wdata,
  input  logic              dma_rdr_rd,
  input  logic              sts_rd,
  input  logic              sts_wr,
  input  logic [FLAG_N-1:0] sts_wdata,
  input  logic              en_tx,
  input  logic              en_rx,
  input  logic              en_txend,
  output logic [FLAG_N-1:0] sts_rdata,
  output logic [DATA_W-1:0] tdr_data,
  output logic              irq_rxerr,
  output logic              irq_rxfull,
  output logic              irq_txempty,
  output logic              irq_txend,
  output logic              dma_rx_trig,
  output logic              dma_tx_trig,
  output logic [1:0]        irq_src,
  output logic              irq_valid
);
  logic [FLAG_N-1:0] flags, flag_set, flag_hw_clr, flag_sw_clr;
  logic [REQ_N-1:0]  req;
  logic              tdr_any_wr;

  assign tdr_any_wr = cpu_tdr_wr | dma_tdr_wr;

  always_comb begin
    flag_set            = '0;
    flag_hw_clr         = '0;
    flag_set[F_TXE]     = ev_tx_load;
    flag_set[F_RXF]     = ev_rx_done;
    flag_set[F_OVR]     = ev_overrun;
    flag_set[F_FRM]     = ev_frame_err;
    flag_set[F_PAR]     = ev_parity_err;
    flag_set[F_TEND]    = ev_stop_done & flags[F_TXE];
    flag_hw_clr[F_TXE]  = dma_tdr_wr;
    flag_hw_clr[F_RXF]  = dma_rdr_rd;
    flag_hw_clr[F_TEND] = tdr_any_wr;
  end

  flag_clr_ctl #(.N(FLAG_N)) u_clr (
    .clk(clk), .rst_n(rst_n), .rd_i(sts_rd), .wr_i(sts_wr),
    .wdata_i(sts_wdata), .flags_i(flags), .sw_clr_o(flag_sw_clr)
  );

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
      .clk(clk), .rst_n(rst_n), .set_i(flag_set[i]),
      .hw_clr_i(flag_hw_clr[i]), .sw_clr_i(flag_sw_clr[i]), .q(flags[i])
    );
  end

  tdr_hold #(.DATA_W(DATA_W)) u_tdr (
    .clk(clk), .rst_n(rst_n), .wr_i(tdr_any_wr), .wdata_i(tdr_wdata), .q(tdr_data)
  );

  irq_prio u_prio (
    .clk(clk), .rst_n(rst_n), .flags_i(flags), .en_tx(en_tx), .en_rx(en_rx),
    .en_txend(en_txend), .req_o(req), .dma_rx_trig(dma_rx_trig),
    .dma_tx_trig(dma_tx_trig), .src_o(irq_src), .valid_o(irq_valid)
  );

  assign sts_rdata   = flags;
  assign irq_rxerr   = req[0];
  assign irq_rxfull  = req[1];
  assign irq_txempty = req[2];
  assign irq_txend   = req[3];

  assert_tend_after_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_TEND]) |-> $past(flags[F_TXE]));
  assert_dma_clears_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tdr_wr && !ev_tx_load) |=> !sts_rdata[F_TXE]);
endmodule

// File: tb/sim_uart_flag_irq.sv
module sim_uart_flag_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_tx_load = 0, ev_stop_done = 0, ev_rx_done = 0;
  logic ev_overrun = 0, ev_frame_err = 0, ev_parity_err = 0;
  logic cpu_tdr_wr = 0, dma_tdr_wr = 0, dma_rdr_rd = 0;
  logic [7:0] tdr_wdata = 8'h00;
  logic sts_rd = 0, sts_wr = 0;
  logic [5:0] sts_wdata = 6'h00;
  logic en_tx = 0, en_rx = 0, en_txend = 0;
  logic [5:0] sts_rdata;
  logic [7:0] tdr_data;
  logic irq_rxerr, irq_rxfull, irq_txempty, irq_txend;
  logic dma_rx_trig, dma_tx_trig, irq_valid;
  logic [1:0] irq_src;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_flag_irq #(.DATA_W(8)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic clear_all_events;
    ev_tx_load = 0; ev_stop_done = 0; ev_rx_done = 0; ev_overrun = 0;
    ev_frame_err = 0; ev_parity_err = 0; cpu_tdr_wr = 0; dma_tdr_wr = 0;
    dma_rdr_rd = 0; sts_rd = 0; sts_wr = 0;
  endtask

  task automatic t_reset;
    check("R1 status", sts_rdata, 6'b100001);
    check("R1 irqs", {irq_rxerr, irq_rxfull, irq_txempty, irq_txend}, 0);
    check("R1 valid", irq_valid, 0);
    check("R1 strobes", {dma_rx_trig, dma_tx_trig}, 0);
    check("R1 tdr", tdr_data, 0);
  endtask

  task automatic t_transmit;
    en_tx = 1;
    step;
    check("R2 txempty req", irq_txempty, 1);
    dma_tdr_wr = 1; tdr_wdata = 8'hA5; step; clear_all_events;
    check("R6 dma clears txe", sts_rdata[0], 0);
    check("R5 write clears tend", sts_rdata[5], 0);
    check("R11 dma data", tdr_data, 8'hA5);
    cpu_tdr_wr = 1; tdr_wdata = 8'h3C; step; clear_all_events;
    check("R11 overwrite", tdr_data, 8'h3C);
    check("R6 cpu keeps txe", sts_rdata[0], 0);
    ev_stop_done = 1; step; clear_all_events;
    check("R5 no tend while full", sts_rdata[5], 0);
    ev_tx_load = 1; step; clear_all_events;
    check("R2 txe set", sts_rdata[0], 1);
    check("R7 tx strobe", dma_tx_trig, 1);
    check("R8 src txempty", irq_src, 2);
    step;
    check("R7 tx strobe one cycle", dma_tx_trig, 0);
    ev_stop_done = 1; step; clear_all_events;
    check("R5 tend set", sts_rdata[5], 1);
    check("R5 tend gated", irq_txend, 0);
    en_txend = 1; en_tx = 0; step;
    check("R5 tend req", irq_txend, 1);
    check("R8 src txend", irq_src, 3);
    check("R7 no strobe for tend", {dma_rx_trig, dma_tx_trig}, 0);
    en_tx = 1; step;
  endtask

  task automatic t_receive;
    en_rx = 1;
    ev_rx_done = 1; step; clear_all_events;
    check("R3 rxf set", sts_rdata[1], 1);
    check("R3 rxf req", irq_rxfull, 1);
    check("R7 rx strobe", dma_rx_trig, 1);
    check("R8 src rxfull", irq_src, 1);
    step;
    check("R7 rx strobe one cycle", dma_rx_trig, 0);
    dma_rdr_rd = 1; step; clear_all_events;
    check("R6 dma clears rxf", sts_rdata[1], 0);
    ev_rx_done = 1; dma_rdr_rd = 1; step; clear_all_events;
    check("R10 set beats dma clear", sts_rdata[1], 1);
  endtask

  task automatic t_errors;
    ev_overrun = 1; step; clear_all_events;
    check("R4 overrun bit", sts_rdata[2], 1);
    check("R4 err req", irq_rxerr, 1);
    check("R8 src rxerr", irq_src, 0);
    check("R7 no strobe for err", dma_rx_trig, 0);
    ev_frame_err = 1; ev_parity_err = 1; step; clear_all_events;
    check("R4 frame parity bits", sts_rdata[4:3], 2'b11);
    en_rx = 0; step;
    check("R4 rx enable gates", {irq_rxerr, irq_rxfull}, 0);
    en_rx = 1; step;
  endtask

  task automatic t_cpu_clear;
    // status now: tend=1, par=1, frm=1, ovr=1, rxf=1, txe=1
    sts_wr = 1; sts_wdata = 6'b111011; step; clear_all_events;
    check("R9 write without read", sts_rdata, 6'b111111);
    sts_rd = 1; step; clear_all_events;
    sts_wr = 1; sts_wdata = 6'b111011; step; clear_all_events;
    check("R9 read then write0", sts_rdata, 6'b111011);
    sts_wr = 1; sts_wdata = 6'b101111; step; clear_all_events;
    check("R9 single use of read", sts_rdata, 6'b111011);
    sts_rd = 1; step; clear_all_events;
    sts_wr = 1; sts_wdata = 6'b111111; step; clear_all_events;
    check("R9 write1 no effect", sts_rdata, 6'b111011);
    sts_rd = 1; step; clear_all_events;
    sts_wr = 1; sts_wdata = 6'b000000; ev_rx_done = 1; step; clear_all_events;
    check("R10 set beats cpu clear", sts_rdata, 6'b000010);
    en_tx = 0; en_txend = 0; dma_rdr_rd = 1; step; clear_all_events;
    check("R8 none pending valid", irq_valid, 0);
    check("R8 none pending src", irq_src, 0);
  endtask

  initial begin
    repeat (3) step;
    rst_n = 1;
    step;
    t_reset;
    t_transmit;
    t_receive;
    t_errors;
    t_cpu_clear;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule